// File: doc/BRIEF.md
# Indirect Register File Access Unit

This block resolves the file address of each register-file access made by an instruction. A file-address field normally selects a register directly. One file address is reserved for a virtual indirect register that has no storage of its own: an access naming it is redirected to the location held in a pointer register, extended by a bank-select bit from the status register into a wider effective address. The unit produces the effective address and the write strobe for the storage array. It also returns read data, forcing it to zero when the pointer refers back to the indirect register.

Requests enter on a valid/ready stream. A request is accepted in the cycle where `req_valid` and `req_ready` are both high. Read results leave on a second valid/ready stream, held in a one-entry register. The response side applies back-pressure: `req_ready` is low only while a response is pending and `rsp_ready` is low, so a read cannot be lost. The storage array is asynchronous-read and sits outside the block, as does the ALU. Pointer and bank inputs are taken as they stand in the accepting cycle, so a pointer update made between two accesses applies to the second.

Top module: `ind_access_unit`

## Requirements
- R1: An accepted access whose file address field is not the indirect address (0x00) drives `rf_addr` with that field zero-extended to 9 bits.
- R2: An accepted access to file address 0x00 drives `rf_addr` with `{bank_sel, ptr_q}`, the bank bit as bit 8.
- R3: An indirect read whose pointer has its low 7 bits equal to 0x00 (self-reference, either bank) returns 0x00 on `rsp_data`, whatever the array holds.
- R4: An indirect write with self-reference keeps `rf_we` low while `flag_upd` is still high in the accepting cycle, and leaves the array unchanged.
- R5: Any other accepted write raises `rf_we` for exactly the accepting cycle, with `rf_wdata` equal to `req_wdata` and `flag_upd` high.
- R6: An accepted read presents the array data from the accepting cycle on `rsp_data`, with `rsp_valid` high, from the next cycle. The response is held stable while `rsp_ready` is low. A read-and-write request returns the value from before the write.
- R7: `req_ready` equals `!rsp_valid || rsp_ready`. Without an accepted request, `rf_we` and `flag_upd` stay low.
- R8: After reset, `rsp_valid` is low and `req_ready` is high.
- R9: A pointer change between accesses applies to the next access. A loop that writes zero indirectly while stepping the pointer from 0x40 until pointer bit 7 sets clears exactly locations 0x40 to 0x7F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_faddr | input | 7 | File address field of the instruction |
| req_rd | input | 1 | Request reads the register |
| req_wr | input | 1 | Request writes the register |
| req_wdata | input | 8 | Write data from the ALU |
| ptr_q | input | 8 | Current pointer register contents |
| bank_sel | input | 1 | Bank bit from the status register |
| rf_addr | output | 9 | Effective address to the storage array |
| rf_we | output | 1 | Write enable to the storage array |
| rf_wdata | output | 8 | Write data to the storage array |
| rf_rdata | input | 8 | Asynchronous read data from the array |
| flag_upd | output | 1 | Status-flag update strobe for any accepted write |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Consumer accepts the response |
| rsp_data | output | 8 | Read data, zero on self-reference |

## Verification
The hardest case to reach is self-reference under a bank bit and pointer top bit that are not zero. Examples are pointer 0x80 or bank 1 with pointer 0x00, where the 9-bit address is not 0x00 but the low 7 bits match. The stimulus sets a nonzero array value at 0x000 and 0x100 and then issues indirect reads and writes with these pointer values. Some of these requests arrive while `rsp_ready` is toggled pseudo-randomly, so forced-zero responses are also held under back-pressure. The pointer-stepping clear loop then shows that each pointer update lands on the following access.

// File: rtl/ind_access_pkg.sv
package ind_access_pkg;
  parameter int unsigned FA_W  = 7;
  parameter int unsigned PTR_W = 8;
  parameter int unsigned DW    = 8;
  localparam int unsigned EA_W = PTR_W + 1;

  typedef enum logic [1:0] {
    ACC_DIRECT   = 2'd0,
    ACC_INDIRECT = 2'd1,
    ACC_SELFREF  = 2'd2
  } acc_kind_e;

  typedef struct packed {
    logic            rd;
    logic            wr;
    logic [DW-1:0]   wdata;
  } acc_op_t;
endpackage

// File: rtl/ind_addr_resolve.sv
module ind_addr_resolve
  import ind_access_pkg::*;
#(
  parameter int unsigned          P_FA_W  = FA_W,
  parameter int unsigned          P_PTR_W = PTR_W,
  parameter logic [P_FA_W-1:0]    IND_ADDR = '0,
  localparam int unsigned         P_EA_W  = P_PTR_W + 1
) (
  input  logic [P_FA_W-1:0]   faddr,
  input  logic [P_PTR_W-1:0]  ptr,
  input  logic                bank,
  output logic [P_EA_W-1:0]   eaddr,
  output acc_kind_e           kind
);
  logic               names_ind;
  logic [P_EA_W-1:0]  ind_ea;
  logic [P_EA_W-1:0]  dir_ea;

  assign names_ind = (faddr == IND_ADDR);
  assign ind_ea    = {bank, ptr};

  generate
    if (P_EA_W > P_FA_W) begin : g_zext
      assign dir_ea = {{(P_EA_W-P_FA_W){1'b0}}, faddr};
    end else begin : g_trunc
      assign dir_ea = faddr[P_EA_W-1:0];
    end
  endgenerate

  always_comb begin
    if (!names_ind) begin
      eaddr = dir_ea;
      kind  = ACC_DIRECT;
    end else begin
      eaddr = ind_ea;
      kind  = (ind_ea[P_FA_W-1:0] == IND_ADDR) ? ACC_SELFREF : ACC_INDIRECT;
    end
  end
endmodule

// File: rtl/ind_write_gate.sv
module ind_write_gate
  import ind_access_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fire,
  input  logic       wr,
  input  acc_kind_e  kind,
  output logic       we,
  output logic       flag_upd
);
  logic wr_fire;

  assign wr_fire  = fire && wr;
  assign flag_upd = wr_fire;
  assign we       = wr_fire && (kind != ACC_SELFREF);

  // R4
  selfref_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && wr && kind == ACC_SELFREF) |-> (!we && flag_upd));

  // R7
  idle_no_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fire) |-> (!we && !flag_upd));
endmodule

// File: rtl/ind_rsp_reg.sv
module ind_rsp_reg
  import ind_access_pkg::*;
#(
  parameter int unsigned P_DW = DW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic            zero,
  input  logic [P_DW-1:0] din,
  output logic            valid,
  input  logic            ready,
  output logic [P_DW-1:0] data,
  output logic            slot_free
);
  assign slot_free = !valid || ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      data  <= '0;
    end else begin
      if (load) begin
        valid <= 1'b1;
        data  <= zero ? '0 : din;
      end else if (ready) begin
        valid <= 1'b0;
      end
    end
  end

  // R6
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready) |=> (valid && $stable(data)));

  // R6
  rsp_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid) |-> $past(load));

  // R3
  rsp_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && zero) |=> (valid && data == '0));
endmodule

// File: rtl/ind_access_unit.sv
module ind_access_unit
  import ind_access_pkg::*;
#(
  parameter int unsigned       T_FA_W  = FA_W,
  parameter int unsigned       T_PTR_W = PTR_W,
  parameter int unsigned       T_DW    = DW,
  parameter logic [T_FA_W-1:0] T_IND   = '0,
  localparam int unsigned      T_EA_W  = T_PTR_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [T_FA_W-1:0]  req_faddr,
  input  logic               req_rd,
  input  logic               req_wr,
  input  logic [T_DW-1:0]    req_wdata,
  input  logic [T_PTR_W-1:0] ptr_q,
  input  logic               bank_sel,
  output logic [T_EA_W-1:0]  rf_addr,
  output logic               rf_we,
  output logic [T_DW-1:0]    rf_wdata,
  input  logic [T_DW-1:0]    rf_rdata,
  output logic               flag_upd,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [T_DW-1:0]    rsp_data
);
  acc_kind_e kind;
  logic      fire;
  logic      slot_free;

  assign req_ready = slot_free;
  assign fire      = req_valid && slot_free;
  assign rf_wdata  = req_wdata;

  ind_addr_resolve #(
    .P_FA_W(T_FA_W), .P_PTR_W(T_PTR_W), .IND_ADDR(T_IND)
  ) u_resolve (
    .faddr(req_faddr), .ptr(ptr_q), .bank(bank_sel),
    .eaddr(rf_addr), .kind(kind)
  );

  ind_write_gate u_wgate (
    .clk(clk), .rst_n(rst_n), .fire(fire), .wr(req_wr),
    .kind(kind), .we(rf_we), .flag_upd(flag_upd)
  );

  ind_rsp_reg #(.P_DW(T_DW)) u_rsp (
    .clk(clk), .rst_n(rst_n),
    .load(fire && req_rd), .zero(kind == ACC_SELFREF), .din(rf_rdata),
    .valid(rsp_valid), .ready(rsp_ready), .data(rsp_data),
    .slot_free(slot_free)
  );

  // R7
  stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> (!req_ready && !rf_we));

  // R5
  we_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_we && !req_valid) |-> 1'b0);

  // R6
  rsp_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && req_rd && kind != ACC_SELFREF) |=> (rsp_data == $past(rf_rdata)));
endmodule

// File: tb/ind_access_unit_tb.sv
module ind_access_unit_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [6:0] req_faddr = '0;
  logic       req_rd = 1'b0;
  logic       req_wr = 1'b0;
  logic [7:0] req_wdata = '0;
  logic [7:0] ptr_q = '0;
  logic       bank_sel = 1'b0;
  logic [8:0] rf_addr;
  logic       rf_we;
  logic [7:0] rf_wdata;
  logic [7:0] rf_rdata;
  logic       flag_upd;
  logic       rsp_valid;
  logic       rsp_ready = 1'b1;
  logic [7:0] rsp_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit rnd_ready = 0;
  int lfsr = 32'h1234_5678;

  logic [7:0] store [0:511];
  int mmem [0:511];
  bit m_rv = 0;
  int m_rd = 0;

  always #4 clk = ~clk;

  ind_access_unit u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_faddr(req_faddr), .req_rd(req_rd), .req_wr(req_wr), .req_wdata(req_wdata),
    .ptr_q(ptr_q), .bank_sel(bank_sel), .rf_addr(rf_addr), .rf_we(rf_we),
    .rf_wdata(rf_wdata), .rf_rdata(rf_rdata), .flag_upd(flag_upd),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data)
  );

  assign rf_rdata = store[rf_addr];
  always @(posedge clk) if (rf_we) store[rf_addr] <= rf_wdata;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // reference: cycle-by-cycle compare at negedge, then advance the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int ea;
      bit ind, self, ready_e, fire;
      ind  = (req_faddr == 0);
      ea   = ind ? (bank_sel * 256 + ptr_q) : req_faddr;
      self = ind && ((ptr_q % 128) == 0);
      ready_e = !m_rv || rsp_ready;
      fire = req_valid && ready_e;
      chk("R7 req_ready", req_ready, ready_e);
      chk("R7 rsp_valid", rsp_valid, m_rv);
      if (m_rv) chk("R6 rsp_data", rsp_data, m_rd);
      if (fire) chk(ind ? "R2 rf_addr" : "R1 rf_addr", rf_addr, ea);
      chk("R5 rf_we", rf_we, fire && req_wr && !self);
      chk("R4 flag_upd", flag_upd, fire && req_wr);
      if (fire && req_wr) chk("R5 rf_wdata", rf_wdata, req_wdata);
      if (m_rv && rsp_ready) m_rv = 0;
      if (fire && req_rd) begin
        m_rv = 1;
        m_rd = self ? 0 : mmem[ea];
      end
      if (fire && req_wr && !self) mmem[ea] = req_wdata;
    end
  end

  initial begin
    forever begin
      @(posedge clk); #1;
      lfsr = (lfsr << 1) ^ ((lfsr < 0) ? 32'h04C1_1DB7 : 0);
      rsp_ready = rnd_ready ? lfsr[5] : 1'b1;
    end
  end

  task automatic access(input int fa, input bit rd, input bit wr, input int wd);
    req_faddr = fa[6:0]; req_rd = rd; req_wr = wr; req_wdata = wd[7:0];
    req_valid = 1'b1;
    forever begin
      @(negedge clk);
      if (req_ready) break;
    end
    @(posedge clk); #1;
    req_valid = 1'b0; req_rd = 1'b0; req_wr = 1'b0;
  endtask

  task automatic drain();
    rnd_ready = 0;
    repeat (3) @(posedge clk);
    #1;
  endtask

  initial begin
    for (int i = 0; i < 512; i++) begin
      store[i] = 8'((i * 7) ^ 8'h3C) | 8'h01;
      mmem[i] = store[i];
    end
    store[0] = 8'hA5; mmem[0] = 8'hA5;
    store[256] = 8'h5A; mmem[256] = 8'h5A;
    repeat (3) @(posedge clk);
    #1;
    // R8 reset state
    chk("R8 rsp_valid", rsp_valid, 0);
    chk("R8 req_ready", req_ready, 1);
    rst_n = 1'b1;
    @(posedge clk); #1;

    // R1 direct reads and writes
    access(7'h15, 1, 0, 0);
    access(7'h22, 0, 1, 8'h9E);
    access(7'h22, 1, 0, 0);
    access(7'h7F, 1, 1, 8'h11);   // R6 read-then-write returns old value
    access(7'h7F, 1, 0, 0);

    // R2 indirect, both banks
    ptr_q = 8'h33; bank_sel = 0; access(0, 0, 1, 8'hC4);
    bank_sel = 1;  access(0, 0, 1, 8'h4C);
    bank_sel = 0;  access(0, 1, 0, 0);
    bank_sel = 1;  access(0, 1, 0, 0);
    ptr_q = 8'hF0; access(0, 1, 0, 0);

    // R3 / R4 self reference in each form
    ptr_q = 8'h00; bank_sel = 0; access(0, 1, 0, 0);
    ptr_q = 8'h80; access(0, 1, 0, 0);
    ptr_q = 8'h00; bank_sel = 1; access(0, 1, 1, 8'h77);
    ptr_q = 8'h80; access(0, 0, 1, 8'h66);
    drain();
    chk("R4 store[0x000] kept", store[0], 8'hA5);
    chk("R4 store[0x100] kept", store[256], 8'h5A);
    chk("R4 store[0x180] kept", store[384], mmem[384]);

    // R6 / R7 back-pressure with random response ready
    rnd_ready = 1;
    for (int k = 0; k < 60; k++) begin
      ptr_q = 8'(k * 37); bank_sel = k[0];
      access((k % 3 == 0) ? 0 : (k * 11) % 128, 1, k[1], k * 5);
    end
    drain();

    // R9 fill then pointer-stepping clear
    bank_sel = 0;
    for (int a = 8'h40; a < 8'h80; a++) begin
      ptr_q = 8'(a); access(0, 0, 1, 8'hE1);
    end
    chk("R9 store[0x3F] before", store[8'h3F], mmem[8'h3F]);
    ptr_q = 8'h40;
    while (!ptr_q[7]) begin
      access(0, 0, 1, 0);
      ptr_q = ptr_q + 8'd1;
    end
    drain();
    for (int a = 8'h40; a < 8'h80; a++) chk("R9 cleared", store[a], 0);
    chk("R9 store[0x3F] untouched", store[8'h3F], mmem[8'h3F]);
    chk("R9 store[0x80] untouched", store[8'h80], mmem[8'h80]);
    chk("R9 store[0x140] untouched", store[9'h140], mmem[9'h140]);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule